// File: doc/BRIEF.md
# Programmable 16x Baud Clock Divider

This block divides the system clock by a 16-bit value that a host programs. The output is a one-cycle enable pulse at sixteen times the serial bit rate, so a transmitter or receiver can step its oversampling logic on that pulse. The divisor for a given rate is the input clock frequency divided by sixteen times the baud rate. A second output is a square wave that inverts on each enable pulse, which gives a 50 % duty signal at half the enable rate.

The host reaches two byte-wide divisor latches through a small register port. The port has a 3-bit address, an active-low chip select, and active-low write and read strobes. Both latches read back what was written. Writing either latch reloads the down-counter on the next clock edge. The first period after a reprogram therefore uses the new divisor straight away and does not wait for the old count to run out.

Top module: `baud_gen16`

## Requirements
- R1: After synchronous reset both latches hold 0, and `baud_en`, `baud_out` and `rdata` are 0.
- R2: With `cs_n` and `wr_n` low at a rising edge, `wdata` is stored in the low divisor byte when `addr` is 0 and in the high byte when `addr` is 1. With `cs_n` and `rd_n` low at a rising edge, `rdata` shows the addressed byte after that edge. At all other times `rdata` is 0.
- R3: When `cs_n` is high, the strobes have no effect. Writes to addresses 2 to 7 change nothing, and reads of those addresses return 0.
- R4: A write to either latch at edge E loads the counter at edge E+1. For a divisor N of at least 1, the first `baud_en` pulse is seen after edge E+N+1.
- R5: With a steady divisor N of at least 2, `baud_en` is high for exactly one cycle in every N cycles.
- R6: A divisor of 1 holds `baud_en` high on every cycle.
- R7: A divisor of 0 keeps `baud_en` low.
- R8: `baud_out` inverts on the edge that ends each `baud_en` pulse and holds its value at every other edge.
- R9: A divisor write in the middle of a count drops the rest of the old count. The next pulse follows the timing in R4.
- R10: Every divisor from 1 to 65535 is honoured, including the largest value built from both bytes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| cs_n | input | 1 | Chip select, active low |
| wr_n | input | 1 | Write strobe, active low |
| rd_n | input | 1 | Read strobe, active low |
| addr | input | 3 | Register address (0 low byte, 1 high byte) |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Registered read data |
| baud_en | output | 1 | One-cycle enable at 16x baud rate |
| baud_out | output | 1 | Square wave toggling on each enable |

## Verification
Errors in the counter show up at `baud_en` within one divisor period. A missed reload shows up as a first pulse that is late by the rest of the old count. An off-by-one in the compare shows up as a period of N-1 or N+1, or as a pulse wider than one cycle. Errors in the latches show up on the next readback, and also as wrong spacing of the pulses after the following reload. The largest divisor is run to the end so that a dropped high-byte bit cannot hide. A wrong toggle register shows up on `baud_out` in the cycle right after a pulse.

// File: rtl/bg_pkg.sv
package bg_pkg;
  localparam int unsigned BG_DATA_W = 8;
  localparam int unsigned BG_ADDR_W = 3;
  localparam int unsigned BG_NBYTES = 2;
endpackage

// File: rtl/bg_regs.sv
module bg_regs #(
  parameter int unsigned DATA_W = bg_pkg::BG_DATA_W,
  parameter int unsigned ADDR_W = bg_pkg::BG_ADDR_W,
  parameter int unsigned NBYTES = bg_pkg::BG_NBYTES,
  localparam int unsigned DIV_W = DATA_W * NBYTES
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cs_n,
  input  logic              wr_n,
  input  logic              rd_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic [DIV_W-1:0]  div,
  output logic              load
);
  logic wr_en, rd_en, hit;
  logic [NBYTES-1:0][DATA_W-1:0] byte_q;
  logic [DATA_W-1:0] rd_mux;

  assign wr_en = !cs_n && !wr_n;
  assign rd_en = !cs_n && !rd_n;
  assign hit   = addr < ADDR_W'(NBYTES);

  genvar g;
  generate
    for (g = 0; g < NBYTES; g++) begin : g_byte
      always_ff @(posedge clk) begin
        if (rst) byte_q[g] <= '0;
        else if (wr_en && addr == ADDR_W'(g)) byte_q[g] <= wdata;
      end
      // R3: an unselected port leaves every latch untouched
      p_unselected_hold_r3: assert property (@(posedge clk) disable iff (rst)
        cs_n |=> $stable(byte_q[g]));
    end
  endgenerate

  always_comb begin
    rd_mux = '0;
    for (int i = 0; i < NBYTES; i++)
      if (addr == ADDR_W'(i)) rd_mux = byte_q[i];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata <= '0;
      load  <= 1'b0;
    end else begin
      rdata <= rd_en ? rd_mux : '0;
      load  <= wr_en && hit;
    end
  end

  assign div = byte_q;

  // R2: read data is zero unless a selected read was sampled
  p_rdata_idle_r2: assert property (@(posedge clk) disable iff (rst)
    !rd_en |=> rdata == '0);
  // R4: a decoded write always requests a reload
  p_write_reload_r4: assert property (@(posedge clk) disable iff (rst)
    (wr_en && hit) |=> load);
endmodule

// File: rtl/bg_counter.sv
module bg_counter #(
  parameter int unsigned DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [DIV_W-1:0] div,
  input  logic             load,
  output logic             tick
);
  logic [DIV_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
      tick  <= 1'b0;
    end else if (load) begin
      cnt_q <= div;
      tick  <= 1'b0;
    end else if (div == '0) begin
      cnt_q <= '0;
      tick  <= 1'b0;
    end else if (cnt_q <= DIV_W'(1)) begin
      cnt_q <= div;
      tick  <= (cnt_q == DIV_W'(1));
    end else begin
      cnt_q <= cnt_q - 1'b1;
      tick  <= 1'b0;
    end
  end

  // R7: zero divisor never pulses
  p_zero_quiet_r7: assert property (@(posedge clk) disable iff (rst)
    div == '0 |=> !tick);
  // R4: reload takes the current divisor and suppresses a pulse
  p_reload_r4: assert property (@(posedge clk) disable iff (rst)
    load |=> (cnt_q == $past(div)) && !tick);
  // R5: terminal count yields a pulse and a fresh period
  p_terminal_r5: assert property (@(posedge clk) disable iff (rst)
    (!load && div != '0 && cnt_q == DIV_W'(1)) |=> tick && cnt_q == $past(div));
  // R5: a pulse only follows a count of one
  p_pulse_src_r5: assert property (@(posedge clk) disable iff (rst)
    !(cnt_q == DIV_W'(1)) |=> !tick);
endmodule

// File: rtl/bg_toggle.sv
module bg_toggle (
  input  logic clk,
  input  logic rst,
  input  logic tick,
  output logic wave
);
  always_ff @(posedge clk) begin
    if (rst) wave <= 1'b0;
    else if (tick) wave <= ~wave;
  end

  // R8: inversion after a pulse, hold otherwise
  p_flip_r8: assert property (@(posedge clk) disable iff (rst)
    tick |=> wave != $past(wave));
  p_hold_r8: assert property (@(posedge clk) disable iff (rst)
    !tick |=> $stable(wave));
endmodule

// File: rtl/baud_gen16.sv
module baud_gen16 #(
  parameter int unsigned DATA_W = bg_pkg::BG_DATA_W,
  parameter int unsigned ADDR_W = bg_pkg::BG_ADDR_W,
  parameter int unsigned NBYTES = bg_pkg::BG_NBYTES
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cs_n,
  input  logic              wr_n,
  input  logic              rd_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic              baud_en,
  output logic              baud_out
);
  localparam int unsigned DIV_W = DATA_W * NBYTES;

  logic [DIV_W-1:0] div;
  logic             load;

  bg_regs #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .NBYTES(NBYTES)) u_regs (
    .clk(clk), .rst(rst), .cs_n(cs_n), .wr_n(wr_n), .rd_n(rd_n),
    .addr(addr), .wdata(wdata), .rdata(rdata), .div(div), .load(load)
  );

  bg_counter #(.DIV_W(DIV_W)) u_cnt (
    .clk(clk), .rst(rst), .div(div), .load(load), .tick(baud_en)
  );

  bg_toggle u_tog (
    .clk(clk), .rst(rst), .tick(baud_en), .wave(baud_out)
  );

  // R1: outputs quiet in the cycle after reset
  p_reset_quiet_r1: assert property (@(posedge clk)
    rst |=> !baud_en && !baud_out && rdata == '0);
endmodule

// File: tb/baud_gen16_tb.sv
module baud_gen16_tb;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cs_n = 1'b1, wr_n = 1'b1, rd_n = 1'b1;
  logic [2:0] addr = '0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic baud_en, baud_out;
  int n_run = 0, n_fail = 0;

  always #10 clk = ~clk;

  baud_gen16 u_dut (
    .clk(clk), .rst(rst), .cs_n(cs_n), .wr_n(wr_n), .rd_n(rd_n),
    .addr(addr), .wdata(wdata), .rdata(rdata),
    .baud_en(baud_en), .baud_out(baud_out)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d, input logic sel_n = 1'b0);
    addr = a; wdata = d; cs_n = sel_n; wr_n = 1'b0;
    @(posedge clk); @(negedge clk);
    cs_n = 1'b1; wr_n = 1'b1;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    addr = a; cs_n = 1'b0; rd_n = 1'b0;
    @(posedge clk); @(negedge clk);
    d = rdata;
    cs_n = 1'b1; rd_n = 1'b1;
  endtask

  task automatic wait_tick(input int lim, output int n);
    n = 0;
    for (int i = 0; i < lim; i++) begin
      @(posedge clk); @(negedge clk);
      n++;
      if (baud_en) return;
    end
    n = -1;
  endtask

  task automatic t_reset;
    logic [7:0] d;
    chk(baud_en == 1'b0, "R1 baud_en", baud_en, 0);
    chk(baud_out == 1'b0, "R1 baud_out", baud_out, 0);
    chk(rdata == 8'h00, "R1 rdata", rdata, 0);
    rd(3'd0, d); chk(d == 8'h00, "R1 low latch", d, 0);
    rd(3'd1, d); chk(d == 8'h00, "R1 high latch", d, 0);
  endtask

  task automatic t_readback;
    logic [7:0] d;
    wr(3'd0, 8'h5A); wr(3'd1, 8'hC3);
    rd(3'd0, d); chk(d == 8'h5A, "R2 low readback", d, 8'h5A);
    @(posedge clk); @(negedge clk);
    chk(rdata == 8'h00, "R2 rdata idle", rdata, 0);
    rd(3'd1, d); chk(d == 8'hC3, "R2 high readback", d, 8'hC3);
  endtask

  task automatic t_ignore;
    logic [7:0] d;
    wr(3'd0, 8'hAA, 1'b1);
    rd(3'd0, d); chk(d == 8'h5A, "R3 deselected write", d, 8'h5A);
    addr = 3'd0; cs_n = 1'b1; rd_n = 1'b0;
    @(posedge clk); @(negedge clk);
    chk(rdata == 8'h00, "R3 deselected read", rdata, 0);
    rd_n = 1'b1;
    wr(3'd5, 8'h77);
    rd(3'd5, d); chk(d == 8'h00, "R3 unmapped read", d, 0);
    rd(3'd0, d); chk(d == 8'h5A, "R3 unmapped write low", d, 8'h5A);
    rd(3'd1, d); chk(d == 8'hC3, "R3 unmapped write high", d, 8'hC3);
  endtask

  task automatic t_first_and_period;
    int n;
    wr(3'd1, 8'h00); wr(3'd0, 8'd7);
    wait_tick(100, n); chk(n == 8, "R4 first pulse N=7", n, 8);
    @(posedge clk); @(negedge clk);
    chk(baud_en == 1'b0, "R5 pulse width", baud_en, 0);
    wait_tick(100, n); chk(n == 6, "R5 period N=7", n, 6);
    wait_tick(100, n); chk(n == 7, "R5 steady period N=7", n, 7);
  endtask

  task automatic t_div_one;
    int n, hi;
    wr(3'd0, 8'd1);
    wait_tick(20, n); chk(n == 2, "R6 first pulse N=1", n, 2);
    hi = 0;
    for (int i = 0; i < 10; i++) begin
      @(posedge clk); @(negedge clk);
      if (baud_en) hi++;
    end
    chk(hi == 10, "R6 continuous enable", hi, 10);
  endtask

  task automatic t_div_zero;
    int n;
    wr(3'd0, 8'd0);
    wait_tick(300, n); chk(n == -1, "R7 zero divisor", n, -1);
  endtask

  task automatic t_baud;
    int n, tog;
    logic pv, pt;
    wr(3'd0, 8'd4);
    wait_tick(50, n); chk(n == 5, "R4 first pulse N=4", n, 5);
    tog = 0;
    for (int i = 0; i < 40; i++) begin
      pv = baud_out; pt = baud_en;
      @(posedge clk); @(negedge clk);
      if (baud_out != pv) tog++;
      if (pt && baud_out == pv) chk(1'b0, "R8 missed toggle", baud_out, !pv);
      if (!pt && baud_out != pv) chk(1'b0, "R8 stray toggle", baud_out, pv);
    end
    chk(tog == 10, "R8 toggle count", tog, 10);
  endtask

  task automatic t_reload_mid;
    int n;
    wr(3'd0, 8'd200);
    wait_tick(50, n); chk(n == -1, "R9 no pulse before reload", n, -1);
    wr(3'd0, 8'd10);
    wait_tick(300, n); chk(n == 11, "R9 reload mid count", n, 11);
  endtask

  task automatic t_high_byte;
    int n;
    wr(3'd1, 8'h01); wr(3'd0, 8'h03);
    wait_tick(400, n); chk(n == 260, "R10 divisor 259", n, 260);
  endtask

  task automatic t_max;
    int n;
    wr(3'd0, 8'hFF); wr(3'd1, 8'hFF);
    wait_tick(70000, n); chk(n == 65536, "R10 divisor 65535", n, 65536);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0;
    t_reset;
    t_readback;
    t_ignore;
    t_first_and_period;
    t_div_one;
    t_div_zero;
    t_baud;
    t_reload_mid;
    t_high_byte;
    t_max;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_run++; n_fail++;
    $display("FAIL watchdog: actual %0d expected %0d", 200000, 0);
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule